// File: doc/BRIEF.md
# Wavetable Voice Playback Engine

This block plays back stored waveforms for a set of time-multiplexed voices (32 by default). Each output-sample period begins with a `frame_tick` pulse. The engine then visits every voice in index order, one per clock. For each voice that is sounding, it reads one byte from an external synchronous sample memory at the voice's current position. It decodes that byte as either signed linear or mu-law, scales it by a mantissa/exponent volume word, and adds it to a mix. It then moves the voice's fixed-point position forward by the voice's step. When all voices have been visited, the mix is offered as one stereo sample on a valid/ready output. The mix is mono, so the left and right words are equal.

A voice's position carries a 12-bit fraction. When an advanced position reaches the voice's end mark, the engine rewinds the position by the distance between the end mark and the loop mark. It then silences the voice and raises the voice's done flag. A host fills the per-voice registers through a write port. A key-on pulse starts a voice, or restarts it from its stored position.

Back-pressure rules: a finished sample is held on `out_left`/`out_right` with `out_valid` high until `out_ready` is seen high at a clock edge. While a sample is held, or while a frame is still in progress, `frame_tick` is ignored. An ignored tick starts no memory read and advances no position. The sample memory returns `mem_data` one clock after a cycle with `mem_rd` high.

Top module: `wt_voice_engine`

## Requirements
- R1: After reset, `out_valid` is low and every bit of `voice_on` and `voice_done` is low.
- R2: A `frame_tick` accepted while idle yields exactly one output sample. `out_left` and `out_right` both equal the sum, clamped to signed 16 bits, of the contributions of the voices that were on. A voice that is off contributes 0 and causes no memory read.
- R3: A sounding voice reads memory index {bank[3:0], position[31:12]}, 24 bits wide. Bank bits 7:4 have no effect.
- R4: After contributing, a voice's position becomes position + (step << 2), modulo 2^32. This step applies even when the step is not a whole byte.
- R5: With mode bit 0 clear, the byte is taken as a signed 8-bit value and multiplied by 64.
- R6: With mode bit 0 set, let c be the bitwise inverse of the byte and v = ((c[3:0]*2) + 33) << c[6:4]. The sample is 33 - v when c[7] is 1, and v - 33 when c[7] is 0.
- R7: The effective volume is (({1, vol[11:4], 4'b0000}) << vol[15:12]) >> 12. The contribution is floor(sample * volume / 2^21).
- R8: Let end = {end_hi, end_lo, 8'h00} and loop = {loop_hi, loop_lo, 8'h00}. If the advanced position is at or above end, the position is reduced by (end - loop) modulo 2^32, `voice_on` for that voice falls, and `voice_done` rises. The sample read in that frame is still mixed.
- R9: `key_on` for `key_voice` sets that voice's on bit and clears its done bit on the next edge. Playback continues from the stored position.
- R10: While `out_valid` is high and `out_ready` is low, the output words stay unchanged. A `frame_tick` during a held result or a running frame causes no memory read, no position change and no extra output sample.
- R11: A write with `cfg_we` sets one field of voice `cfg_voice` from `cfg_data`. The field codes are: 0 mode bit 0, 1 step, 2 position[31:16], 3 position[15:0], 4 loop_hi, 5 loop_lo (data[7:0]), 6 end_hi, 7 end_lo (data[7:0]), 8 volume, 9 bank (data[7:0]). Codes 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_voice | input | log2(NV) | Voice being written |
| cfg_field | input | 4 | Field code (see R11) |
| cfg_data | input | 16 | Write data |
| key_on | input | 1 | Start pulse for `key_voice` |
| key_voice | input | log2(NV) | Voice to start |
| frame_tick | input | 1 | Output-sample strobe |
| mem_rd | output | 1 | Sample memory read enable |
| mem_addr | output | 24 | Sample memory index |
| mem_data | input | 8 | Byte returned one clock after `mem_rd` |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_left | output | 16 | Left mix, signed |
| out_right | output | 16 | Right mix, signed |
| voice_on | output | NV | Per-voice sounding flags |
| voice_done | output | NV | Per-voice end-reached flags |

## Verification
On every cycle, the assertions check the following. A held sample stays stable and blocks memory traffic. Both channels match. No voice is on and done at once. A done flag only rises on a voice that was sounding. A key-on takes effect on the next edge. The numeric results cannot be shown by the assertions and are left to the bench scenarios: the mu-law and linear decode over every byte value, the volume curve over every exponent, fractional stepping, bank masking, the rewind distance after the end mark, and the single advance across a stalled output. The bench compares these against arithmetic computed from the requirements.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int unsigned POS_W     = 32;
  localparam int unsigned FRAC_W    = 12;
  localparam int unsigned BANK_W    = 4;
  localparam int unsigned BANKREG_W = 8;
  localparam int unsigned MEM_AW    = BANK_W + POS_W - FRAC_W;
  localparam int unsigned MEM_DW    = 8;
  localparam int unsigned STEP_W    = 16;
  localparam int unsigned STEP_SHL  = 2;
  localparam int unsigned MARK_HI_W = 16;
  localparam int unsigned MARK_LO_W = 8;
  localparam int unsigned VOL_W     = 16;
  localparam int unsigned EFF_W     = 16;
  localparam int unsigned SMP_W     = 14;
  localparam int unsigned VOL_DROP  = 21;
  localparam int unsigned PROD_W    = SMP_W + EFF_W + 1;
  localparam int unsigned SCL_W     = PROD_W - VOL_DROP;
  localparam int unsigned OUT_W     = 16;
  localparam int unsigned CFG_W     = 16;
  localparam int unsigned FIELD_W   = 4;

  typedef enum logic [FIELD_W-1:0] {
    FLD_MODE    = 4'd0,
    FLD_STEP    = 4'd1,
    FLD_POS_HI  = 4'd2,
    FLD_POS_LO  = 4'd3,
    FLD_LOOP_HI = 4'd4,
    FLD_LOOP_LO = 4'd5,
    FLD_END_HI  = 4'd6,
    FLD_END_LO  = 4'd7,
    FLD_VOL     = 4'd8,
    FLD_BANK    = 4'd9
  } field_e;

  typedef struct packed {
    logic                 ulaw;
    logic [STEP_W-1:0]    step;
    logic [POS_W-1:0]     pos;
    logic [MARK_HI_W-1:0] loop_hi;
    logic [MARK_LO_W-1:0] loop_lo;
    logic [MARK_HI_W-1:0] end_hi;
    logic [MARK_LO_W-1:0] end_lo;
    logic [VOL_W-1:0]     vol;
    logic [BANK_W-1:0]    bank;
  } voice_regs_t;
endpackage

// File: rtl/wt_voice_regs.sv
module wt_voice_regs
  import wt_pkg::*;
#(
  parameter int unsigned NV = 32,
  localparam int unsigned IDX_W = $clog2(NV)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_voice,
  input  logic [FIELD_W-1:0]   cfg_field,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic                 key_on,
  input  logic [IDX_W-1:0]     key_voice,
  input  logic                 wb_en,
  input  logic [IDX_W-1:0]     wb_idx,
  input  logic [POS_W-1:0]     wb_pos,
  input  logic                 wb_hit,
  input  logic [IDX_W-1:0]     rd_idx,
  output voice_regs_t          rd_regs,
  output logic                 rd_on,
  output logic [NV-1:0]        on_vec,
  output logic [NV-1:0]        done_vec
);
  voice_regs_t [NV-1:0] all_regs;

  for (genvar v = 0; v < NV; v++) begin : g_voice
    voice_regs_t r_q;
    logic        on_q, done_q;
    logic        sel_wb, sel_cfg, sel_key;

    assign sel_wb  = wb_en  && (wb_idx    == IDX_W'(v));
    assign sel_cfg = cfg_we && (cfg_voice == IDX_W'(v));
    assign sel_key = key_on && (key_voice == IDX_W'(v));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q    <= '0;
        on_q   <= 1'b0;
        done_q <= 1'b0;
      end else begin
        if (sel_wb) begin
          r_q.pos <= wb_pos;
          if (wb_hit) begin
            on_q   <= 1'b0;
            done_q <= 1'b1;
          end
        end
        if (sel_cfg) begin
          case (cfg_field)
            FLD_MODE:    r_q.ulaw    <= cfg_data[0];
            FLD_STEP:    r_q.step    <= cfg_data;
            FLD_POS_HI:  r_q.pos[POS_W-1:POS_W/2] <= cfg_data;
            FLD_POS_LO:  r_q.pos[POS_W/2-1:0]     <= cfg_data;
            FLD_LOOP_HI: r_q.loop_hi <= cfg_data;
            FLD_LOOP_LO: r_q.loop_lo <= cfg_data[MARK_LO_W-1:0];
            FLD_END_HI:  r_q.end_hi  <= cfg_data;
            FLD_END_LO:  r_q.end_lo  <= cfg_data[MARK_LO_W-1:0];
            FLD_VOL:     r_q.vol     <= cfg_data;
            FLD_BANK:    r_q.bank    <= cfg_data[BANK_W-1:0];
            default: ;
          endcase
        end
        if (sel_key) begin
          on_q   <= 1'b1;
          done_q <= 1'b0;
        end
      end
    end

    assign all_regs[v] = r_q;
    assign on_vec[v]   = on_q;
    assign done_vec[v] = done_q;
  end

  assign rd_regs = all_regs[rd_idx];
  assign rd_on   = on_vec[rd_idx];
endmodule

// File: rtl/wt_step.sv
module wt_step
  import wt_pkg::*;
(
  input  logic [POS_W-1:0]     pos,
  input  logic [STEP_W-1:0]    step,
  input  logic [MARK_HI_W-1:0] loop_hi,
  input  logic [MARK_LO_W-1:0] loop_lo,
  input  logic [MARK_HI_W-1:0] end_hi,
  input  logic [MARK_LO_W-1:0] end_lo,
  output logic [POS_W-1:0]     nxt,
  output logic                 hit
);
  localparam int unsigned PAD_W = POS_W - MARK_HI_W - MARK_LO_W;

  logic [POS_W-1:0] end_v, loop_v, adv;

  always_comb begin
    end_v  = {end_hi, end_lo, {PAD_W{1'b0}}};
    loop_v = {loop_hi, loop_lo, {PAD_W{1'b0}}};
    adv    = pos + (POS_W'(step) << STEP_SHL);
    hit    = (adv >= end_v);
    nxt    = hit ? (adv - (end_v - loop_v)) : adv;
  end
endmodule

// File: rtl/wt_scale.sv
module wt_scale
  import wt_pkg::*;
(
  input  logic [MEM_DW-1:0]        byte_in,
  input  logic                     ulaw,
  input  logic [VOL_W-1:0]         vol,
  output logic signed [SCL_W-1:0]  contrib
);
  localparam int unsigned MAG_W  = SMP_W - 1;
  localparam int unsigned MANT_W = 13;
  localparam int unsigned WIDE_W = MANT_W + 15;

  logic [MEM_DW-1:0]        c;
  logic [MAG_W-1:0]         base, mag;
  logic signed [SMP_W-1:0]  smp;
  logic [MANT_W-1:0]        mant;
  logic [EFF_W-1:0]         eff;
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    c    = ~byte_in;
    base = MAG_W'(33) + MAG_W'({c[3:0], 1'b0});
    mag  = base << c[6:4];
    if (ulaw)
      smp = c[7] ? (SMP_W'(33) - $signed({1'b0, mag})) : ($signed({1'b0, mag}) - SMP_W'(33));
    else
      smp = $signed({byte_in, 6'b000000});
    mant    = {1'b1, vol[11:4], 4'b0000};
    eff     = EFF_W'((WIDE_W'(mant) << vol[15:12]) >> 12);
    prod    = smp * $signed({1'b0, eff});
    contrib = SCL_W'(prod >>> VOL_DROP);
  end
endmodule

// File: rtl/wt_voice_engine.sv
module wt_voice_engine
  import wt_pkg::*;
#(
  parameter int unsigned NV = 32,
  localparam int unsigned IDX_W = $clog2(NV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_voice,
  input  logic [3:0]         cfg_field,
  input  logic [15:0]        cfg_data,
  input  logic               key_on,
  input  logic [IDX_W-1:0]   key_voice,
  input  logic               frame_tick,
  output logic               mem_rd,
  output logic [23:0]        mem_addr,
  input  logic [7:0]         mem_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [15:0]        out_left,
  output logic [15:0]        out_right,
  output logic [NV-1:0]      voice_on,
  output logic [NV-1:0]      voice_done
);
  localparam int unsigned ACC_W = ((SCL_W + IDX_W) > OUT_W ? (SCL_W + IDX_W) : OUT_W) + 1;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(2 ** (OUT_W - 1));
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NV - 1);

  voice_regs_t rd_regs;
  logic        rd_on;
  logic [POS_W-1:0] nxt_pos;
  logic        hit;

  logic              a_run_q;
  logic [IDX_W-1:0]  idx_q;
  logic              b_tok_q, b_on_q, b_last_q, b_ulaw_q;
  logic [VOL_W-1:0]  b_vol_q;
  logic signed [ACC_W-1:0] acc_q, sum_d, sat_d;
  logic signed [SCL_W-1:0] contrib;
  logic              out_valid_q;
  logic [OUT_W-1:0]  out_q;
  logic              start, issue;

  wt_voice_regs #(.NV(NV)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_voice(cfg_voice),
    .cfg_field(cfg_field),
    .cfg_data (cfg_data),
    .key_on   (key_on),
    .key_voice(key_voice),
    .wb_en    (issue),
    .wb_idx   (idx_q),
    .wb_pos   (nxt_pos),
    .wb_hit   (hit),
    .rd_idx   (idx_q),
    .rd_regs  (rd_regs),
    .rd_on    (rd_on),
    .on_vec   (voice_on),
    .done_vec (voice_done)
  );

  wt_step u_step (
    .pos    (rd_regs.pos),
    .step   (rd_regs.step),
    .loop_hi(rd_regs.loop_hi),
    .loop_lo(rd_regs.loop_lo),
    .end_hi (rd_regs.end_hi),
    .end_lo (rd_regs.end_lo),
    .nxt    (nxt_pos),
    .hit    (hit)
  );

  wt_scale u_scale (
    .byte_in(mem_data),
    .ulaw   (b_ulaw_q),
    .vol    (b_vol_q),
    .contrib(contrib)
  );

  assign start    = frame_tick && !a_run_q && !b_tok_q && !out_valid_q;
  assign issue    = a_run_q && rd_on;
  assign mem_rd   = issue;
  assign mem_addr = {rd_regs.bank, rd_regs.pos[POS_W-1:FRAC_W]};

  always_comb begin
    sum_d = acc_q + (b_on_q ? ACC_W'(contrib) : '0);
    if (sum_d > SAT_HI)      sat_d = SAT_HI;
    else if (sum_d < SAT_LO) sat_d = SAT_LO;
    else                     sat_d = sum_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_run_q     <= 1'b0;
      idx_q       <= '0;
      b_tok_q     <= 1'b0;
      b_on_q      <= 1'b0;
      b_last_q    <= 1'b0;
      b_ulaw_q    <= 1'b0;
      b_vol_q     <= '0;
      acc_q       <= '0;
      out_valid_q <= 1'b0;
      out_q       <= '0;
    end else begin
      if (start) begin
        a_run_q <= 1'b1;
        idx_q   <= '0;
        acc_q   <= '0;
      end
      b_tok_q <= a_run_q;
      if (a_run_q) begin
        idx_q    <= idx_q + 1'b1;
        b_on_q   <= rd_on;
        b_last_q <= (idx_q == LAST);
        b_ulaw_q <= rd_regs.ulaw;
        b_vol_q  <= rd_regs.vol;
        if (idx_q == LAST) a_run_q <= 1'b0;
      end
      if (out_valid_q && out_ready) out_valid_q <= 1'b0;
      if (b_tok_q) begin
        acc_q <= sum_d;
        if (b_last_q) begin
          out_valid_q <= 1'b1;
          out_q       <= OUT_W'(sat_d);
          acc_q       <= '0;
        end
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_left  = out_q;
  assign out_right = out_q;
endmodule

// File: rtl/wt_engine_chk.sv
module wt_engine_chk #(
  parameter int unsigned NV = 32,
  localparam int unsigned IDX_W = $clog2(NV)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_on,
  input logic [IDX_W-1:0] key_voice,
  input logic             frame_tick,
  input logic             mem_rd,
  input logic             out_valid,
  input logic             out_ready,
  input logic [15:0]      out_left,
  input logic [15:0]      out_right,
  input logic [NV-1:0]    voice_on,
  input logic [NV-1:0]    voice_done
);
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_left) && $stable(out_right)));

  p_no_read_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_rd);

  p_tick_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && out_valid) |=> !mem_rd);

  p_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_left == out_right));

  p_on_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_on & voice_done) == '0);

  p_done_from_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_done & ~$past(voice_done) & ~$past(voice_on)) == '0);

  p_key_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |=> (voice_on[$past(key_voice)] && !voice_done[$past(key_voice)]));
endmodule

bind wt_voice_engine wt_engine_chk #(.NV(NV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_on    (key_on),
  .key_voice (key_voice),
  .frame_tick(frame_tick),
  .mem_rd    (mem_rd),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_left  (out_left),
  .out_right (out_right),
  .voice_on  (voice_on),
  .voice_done(voice_done)
);

// File: tb/sim_wt_voice_engine.sv
module sim_wt_voice_engine;
  localparam int NV = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_voice = '0;
  logic [3:0] cfg_field = '0;
  logic [15:0] cfg_data = '0;
  logic key_on = 1'b0;
  logic [IW-1:0] key_voice = '0;
  logic frame_tick = 1'b0;
  logic mem_rd;
  logic [23:0] mem_addr;
  logic [7:0] mem_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [15:0] out_left, out_right;
  logic [NV-1:0] voice_on, voice_done;

  always #10 clk = ~clk;

  wt_voice_engine #(.NV(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_voice(cfg_voice),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .key_on(key_on),
    .key_voice(key_voice), .frame_tick(frame_tick), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
    .voice_on(voice_on), .voice_done(voice_done)
  );

  function automatic logic [7:0] memv(logic [23:0] a);
    return a[7:0] + 8'(a[15:8] * 3) + 8'(a[23:16] * 7);
  endfunction

  int rd_cnt = 0;
  logic [23:0] last_addr = '0;
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_data  <= memv(mem_addr);
      rd_cnt    <= rd_cnt + 1;
      last_addr <= mem_addr;
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // reference state
  bit          m_ulaw [NV];
  logic [15:0] m_step [NV];
  logic [31:0] m_pos  [NV];
  logic [15:0] m_lhi  [NV];
  logic [7:0]  m_llo  [NV];
  logic [15:0] m_ehi  [NV];
  logic [7:0]  m_elo  [NV];
  logic [15:0] m_vol  [NV];
  logic [7:0]  m_bank [NV];
  logic [NV-1:0] m_on = '0;
  logic [NV-1:0] m_done = '0;
  int          m_reads;
  logic [23:0] m_last;

  function automatic int dec(logic [7:0] b, bit ul);
    int c, v;
    if (ul) begin
      c = int'(~b) & 255;
      v = (((c & 15) << 1) + 33) << ((c >> 4) & 7);
      return ((c & 128) != 0) ? 33 - v : v - 33;
    end
    return int'($signed(b)) * 64;
  endfunction

  function automatic int effvol(int vol);
    return (((vol & 'hff0) | 'h1000) << (vol >> 12)) >> 12;
  endfunction

  function automatic int model_frame();
    int sum;
    logic [31:0] adv, endv, loopv;
    logic [23:0] a;
    longint p;
    sum = 0;
    m_reads = 0;
    for (int v = 0; v < NV; v++) begin
      if (m_on[v]) begin
        a = {m_bank[v][3:0], m_pos[v][31:12]};
        m_reads++;
        m_last = a;
        p = longint'(dec(memv(a), m_ulaw[v])) * longint'(effvol(int'(m_vol[v])));
        sum += int'(p >>> 21);
        adv   = m_pos[v] + ({16'h0, m_step[v]} << 2);
        endv  = {m_ehi[v], m_elo[v], 8'h00};
        loopv = {m_lhi[v], m_llo[v], 8'h00};
        if (adv >= endv) begin
          adv = adv - (endv - loopv);
          m_on[v] = 1'b0;
          m_done[v] = 1'b1;
        end
        m_pos[v] = adv;
      end
    end
    if (sum > 32767) sum = 32767;
    if (sum < -32768) sum = -32768;
    return sum;
  endfunction

  task automatic cfg(int v, int f, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_voice = IW'(v); cfg_field = 4'(f); cfg_data = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    case (f)
      0: m_ulaw[v] = d[0];
      1: m_step[v] = 16'(d);
      2: m_pos[v][31:16] = 16'(d);
      3: m_pos[v][15:0] = 16'(d);
      4: m_lhi[v] = 16'(d);
      5: m_llo[v] = 8'(d);
      6: m_ehi[v] = 16'(d);
      7: m_elo[v] = 8'(d);
      8: m_vol[v] = 16'(d);
      9: m_bank[v] = 8'(d);
      default: ;
    endcase
  endtask

  task automatic key(int v);
    @(negedge clk);
    key_on = 1'b1; key_voice = IW'(v);
    @(negedge clk);
    key_on = 1'b0;
    m_on[v] = 1'b1;
    m_done[v] = 1'b0;
  endtask

  task automatic setup(int v, int ul, int step, int pos, int ehi, int elo, int lhi, int llo, int vol, int bank);
    cfg(v, 0, ul); cfg(v, 1, step); cfg(v, 2, pos >>> 16); cfg(v, 3, pos & 'hffff);
    cfg(v, 6, ehi); cfg(v, 7, elo); cfg(v, 4, lhi); cfg(v, 5, llo);
    cfg(v, 8, vol); cfg(v, 9, bank);
  endtask

  task automatic wait_valid(string req);
    int guard = 0;
    while (!out_valid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk(out_valid == 1'b1, req, "out_valid timeout", 0, 1);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic frame(string req);
    int e, r0;
    e = model_frame();
    r0 = rd_cnt;
    pulse_tick();
    wait_valid(req);
    chk($signed(out_left) == e, req, "out_left", longint'($signed(out_left)), e);
    chk(out_right == out_left, req, "out_right", longint'($signed(out_right)), e);
    chk(voice_on == m_on, req, "voice_on", voice_on, m_on);
    chk(voice_done == m_done, req, "voice_done", voice_done, m_done);
    chk(rd_cnt - r0 == m_reads, req, "read count", rd_cnt - r0, m_reads);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int held, r0;
    for (int v = 0; v < NV; v++) begin
      m_ulaw[v] = 0; m_step[v] = 0; m_pos[v] = 0; m_lhi[v] = 0; m_llo[v] = 0;
      m_ehi[v] = 0; m_elo[v] = 0; m_vol[v] = 0; m_bank[v] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(voice_on == '0, "R1", "voice_on in reset", voice_on, 0);
    chk(voice_done == '0, "R1", "voice_done in reset", voice_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    // R2 nothing on: zero sample, no reads
    frame("R2");

    // R6 mu-law sweep over every byte value
    setup(0, 1, 1024, 0, 'hffff, 'hff, 0, 0, 'hfff0, 0);
    key(0);
    for (int i = 0; i < 256; i++) frame("R6");
    // R5 linear sweep
    cfg(0, 0, 0); cfg(0, 2, 0); cfg(0, 3, 0);
    for (int i = 0; i < 256; i++) frame("R5");
    // R7 volume over every exponent
    for (int e = 0; e < 16; e++)
      for (int m = 0; m < 4; m++) begin
        cfg(0, 8, (e << 12) | ((m * 'h55) << 4) | m);
        frame("R7");
      end
    // R3 bank masking
    cfg(0, 9, 'h13);
    frame("R3");
    chk(last_addr == m_last, "R3", "mem_addr bank 0x13", last_addr, m_last);
    cfg(0, 9, 'ha5);
    frame("R3");
    chk(last_addr == m_last, "R3", "mem_addr bank 0xa5", last_addr, m_last);
    // R4 fractional step
    cfg(0, 9, 0); cfg(0, 1, 'h0155); cfg(0, 2, 0); cfg(0, 3, 'h0abc);
    for (int i = 0; i < 24; i++) frame("R4");

    // R2 several voices mixed
    setup(1, 1, 'h0733, 'h00020000, 'hffff, 'hff, 0, 0, 'hf7a0, 2);
    setup(2, 0, 'h0200, 'h00500000, 'hffff, 'hff, 0, 0, 'he550, 5);
    setup(3, 1, 'h1000, 'h00011000, 'hffff, 'hff, 0, 0, 'hfff0, 9);
    key(1); key(2); key(3);
    for (int i = 0; i < 30; i++) frame("R2");

    // R8 force every voice to its end mark
    for (int v = 0; v < NV; v++) begin cfg(v, 6, 0); cfg(v, 7, 0); end
    frame("R8");
    chk(voice_done == 4'hf, "R8", "all done", voice_done, 4'hf);
    frame("R8");
    // R8 end with rewind on voice 1
    setup(1, 0, 'h0400, 0, 0, 'h30, 0, 'h10, 'hfff0, 0);
    key(1);
    for (int i = 0; i < 4; i++) frame("R8");
    chk(voice_done[1] == 1'b1, "R8", "voice1 done", voice_done[1], 1);
    // R9 restart from rewound position
    key(1);
    chk(voice_on[1] == 1'b1 && voice_done[1] == 1'b0, "R9", "key_on flags", {voice_on[1], voice_done[1]}, 2);
    frame("R9");
    chk(last_addr == 24'h000001, "R9", "resume index", last_addr, 24'h000001);

    // R10 back-pressure and dropped ticks
    cfg(1, 6, 'hffff); cfg(1, 7, 'hff); key(1);
    out_ready = 1'b0;
    begin
      int e;
      e = model_frame();
      r0 = rd_cnt;
      @(negedge clk); frame_tick = 1'b1;
      @(negedge clk); frame_tick = 1'b1;   // second tick while frame running
      @(negedge clk); frame_tick = 1'b0;
      wait_valid("R10");
      held = int'($signed(out_left));
      chk(held == e, "R10", "held value", held, e);
      @(negedge clk); frame_tick = 1'b1;   // tick while result held
      @(negedge clk); frame_tick = 1'b0;
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b1, "R10", "still valid", out_valid, 1);
      chk(int'($signed(out_left)) == held, "R10", "stable data", longint'($signed(out_left)), held);
      chk(rd_cnt - r0 == m_reads, "R10", "no extra reads", rd_cnt - r0, m_reads);
      out_ready = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10", "consumed", out_valid, 0);
      repeat (15) @(negedge clk);
      chk(out_valid == 1'b0, "R10", "no extra sample", out_valid, 0);
      chk(rd_cnt - r0 == m_reads, "R10", "reads after drop", rd_cnt - r0, m_reads);
    end
    frame("R10");

    // R11 unused field codes change nothing
    cfg(1, 12, 'hffff);
    cfg(1, 15, 'h0000);
    cfg(1, 10, 'h1234);
    frame("R11");
    frame("R11");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule